// File: doc/BRIEF.md
# Master Clock Ratio Tracker

This block finds out how fast the master clock runs relative to the audio frame clock. It runs on the master clock and receives the frame clock as an asynchronous input. It counts master clock cycles between consecutive rising edges of the frame clock. It then sorts each measured period into one of five supported ratios: 256, 384, 512, 768 or 1024 master cycles per frame.

Once two consecutive periods fall into the same class, the block declares lock. From then on it emits a single-cycle clock enable at exactly 256 times the frame rate, whatever the master clock ratio is. A separate flag tells the downstream converter datapath to double its oversampling rate when the 1024 ratio is in use.

A period that fits no class drops lock and raises an error. A change to a different supported class while locked also drops lock, and the block then re-acquires.

Top module: `mclk_ratio_tracker`

## Requirements
- R1: While reset is low and right after it, `locked`, `ratio_err`, `en_256fs` and `os_256` are 0 and `ratio_code` is 3'd7 (no ratio).
- R2: A period is the number of master clock cycles between two consecutive synchronised rising frame-clock edges. The first edge after reset only starts a measurement. Lock needs two consecutive periods of the same class, so it comes at the third rising edge at the earliest.
- R3: Ratio codes are 3'd0=256, 3'd1=384, 3'd2=512, 3'd3=768 and 3'd4=1024. A period within TOL (default 2) counts of a nominal value belongs to that class.
- R4: A period that matches no class sets `ratio_err`, clears `locked` and returns `ratio_code` to 3'd7. This includes periods longer than the counter range, which saturate and never wrap. `ratio_err` stays set until a supported period is measured.
- R5: While locked, a supported period of a different class clears `locked` at once. Lock returns once the next period repeats the new class.
- R6: While locked, exactly 256 enable pulses occur per frame period. While unlocked, `en_256fs` stays 0.
- R7: The enable spacing follows the ratio. It is every cycle at 256, every 2nd cycle at 512, every 3rd at 768 and every 4th at 1024. At 384 it repeats two active cycles and one idle cycle, so the gaps alternate between one and two cycles.
- R8: `os_256` is 1 exactly when locked at the 1024 ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lrck_async | input | 1 | Frame clock, asynchronous phase |
| ratio_code | output | 3 | Locked ratio code, 3'd7 when unlocked |
| locked | output | 1 | Ratio lock flag |
| en_256fs | output | 1 | Clock enable at 256 times the frame rate |
| os_256 | output | 1 | Oversampling-rate flag (1 = 256fs, 0 = 128fs) |
| ratio_err | output | 1 | Unsupported ratio seen |

## Verification
The bench targets several corner cases, and each one exposes a specific mistake:
- **Tolerance boundary.** It drives periods two counts off nominal, which must lock, and three counts off, which must be rejected. An off-by-one in the window would accept or reject the wrong one.
- **Counter overflow.** A frame period of 2560 cycles would read as 512 in a counter that wraps, and the block would falsely lock.
- **Premature lock.** A design that locks after one measurement, or that counts the first edge after reset as a measurement, shows lock one edge early.
- **Enable patterns.** The enable pattern is counted over a full frame. A 384 divider that alternates periods wrongly would produce more or fewer than 256 pulses, or the wrong gap.
- **Ratio change and error recovery.** A design that ignores a ratio change while locked stays locked. A design that leaves the error set keeps it after a supported period.

// File: rtl/mrt_pkg.sv
// Shared types and helpers for the master clock ratio tracker.
// Assumes five supported ratios, indexed 0..4 in ascending order.
package mrt_pkg;

    localparam int NUM_RATIOS = 5;

    typedef enum logic [2:0] {
        RAT_256  = 3'd0,
        RAT_384  = 3'd1,
        RAT_512  = 3'd2,
        RAT_768  = 3'd3,
        RAT_1024 = 3'd4,
        RAT_NONE = 3'd7
    } ratio_e;

    // Nominal master cycles per frame for ratio index idx.
    function automatic int nominal(input int idx);
        case (idx)
            0:       return 256;
            1:       return 384;
            2:       return 512;
            3:       return 768;
            default: return 1024;
        endcase
    endfunction

    // Last phase value of the enable divider (length minus one).
    function automatic logic [1:0] div_last(input ratio_e r);
        case (r)
            RAT_384:  return 2'd2;
            RAT_512:  return 2'd1;
            RAT_768:  return 2'd2;
            RAT_1024: return 2'd3;
            default:  return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/mrt_edge_sync.sv
// Brings the asynchronous frame clock into the master clock domain and
// flags each rising edge with a one-cycle pulse.
// Assumes the frame clock stays high and low for several master cycles.
module mrt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lrck_async,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Shift the raw input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], lrck_async};
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/mrt_period_meter.sv
// Counts master cycles between consecutive rising frame-clock edges and
// reports each completed period with a one-cycle valid pulse.
// The counter saturates at its maximum; a saturated period reads all ones.
// The first edge after reset only arms the meter.
module mrt_period_meter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_period
);
    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    logic             sat;

    assign sat = (cnt_q == {CNT_W{1'b1}});

    // Saturating cycle counter, restarted at each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (rise) cnt_q <= '0;
        else if (!sat) cnt_q <= cnt_q + 1'b1;
    end

    // Arm on the first edge so later edges close full periods.
    always_ff @(posedge clk) begin
        if (!rst_n)    armed_q <= 1'b0;
        else if (rise) armed_q <= 1'b1;
    end

    // Publish the closed period (count plus the edge cycle itself).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meas_valid  <= 1'b0;
            meas_period <= '0;
        end else begin
            meas_valid  <= rise & armed_q;
            if (rise) meas_period <= sat ? {CNT_W{1'b1}} : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mrt_ratio_classify.sv
// Maps a measured period onto one supported ratio code, with a symmetric
// acceptance window of TOL counts around each nominal value.
// Assumes TOL is far below the 128-count spacing between nominal values.
module mrt_ratio_classify
    import mrt_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int TOL   = 2
) (
    input  logic [CNT_W-1:0] period,
    output ratio_e           code
);
    logic [NUM_RATIOS-1:0] hit;

    for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
        localparam int NOM = nominal(i);
        localparam logic [CNT_W-1:0] LO = CNT_W'(NOM - TOL);
        localparam logic [CNT_W-1:0] HI = CNT_W'(NOM + TOL);
        // Window compare for this ratio.
        assign hit[i] = (period >= LO) && (period <= HI);
    end

    // Encode the matching window; no match yields the no-ratio code.
    always_comb begin
        code = RAT_NONE;
        for (int i = 0; i < NUM_RATIOS; i++) begin
            if (hit[i]) code = ratio_e'(3'(i));
        end
    end
endmodule

// File: rtl/mrt_lock_ctrl.sv
// Qualifies lock: two consecutive periods of the same class lock the ratio.
// An unsupported period or a class change drops lock at once.
// Assumes meas_code is valid in the cycle meas_valid is high.
module mrt_lock_ctrl
    import mrt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   meas_valid,
    input  ratio_e meas_code,
    output logic   locked,
    output ratio_e ratio,
    output logic   err
);
    ratio_e cand_q;

    // Track the last class and update lock, ratio and error per period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= RAT_NONE;
            locked <= 1'b0;
            ratio  <= RAT_NONE;
            err    <= 1'b0;
        end else if (meas_valid) begin
            cand_q <= meas_code;
            if (meas_code == RAT_NONE) begin
                err    <= 1'b1;
                locked <= 1'b0;
                ratio  <= RAT_NONE;
            end else if (meas_code == cand_q) begin
                err    <= 1'b0;
                locked <= 1'b1;
                ratio  <= meas_code;
            end else begin
                err    <= 1'b0;
                locked <= 1'b0;
                ratio  <= RAT_NONE;
            end
        end
    end
endmodule

// File: rtl/mrt_en_divider.sv
// Produces the 256fs clock enable from the locked ratio.
// It divides by 1, 2, 3 or 4; for 384 it emits two enables per three cycles.
// The phase restarts whenever lock is absent.
module mrt_en_divider
    import mrt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   locked,
    input  ratio_e ratio,
    output logic   en
);
    logic [1:0] ph_q;
    logic [1:0] last;

    assign last = div_last(ratio);

    // Phase counter cycling through the divider length.
    always_ff @(posedge clk) begin
        if (!rst_n || !locked) ph_q <= 2'd0;
        else if (ph_q == last) ph_q <= 2'd0;
        else                   ph_q <= ph_q + 2'd1;
    end

    // Decode the enable from the phase.
    always_comb begin
        if (!locked)              en = 1'b0;
        else if (ratio == RAT_384) en = (ph_q != 2'd2);
        else                      en = (ph_q == 2'd0);
    end
endmodule

// File: rtl/mclk_ratio_tracker.sv
// Top level: detects the master-clock-to-frame-clock ratio and derives a
// 256fs clock enable plus an oversampling-rate flag.
// Assumes clk is the master clock and lrck_async has arbitrary phase.
module mclk_ratio_tracker
    import mrt_pkg::*;
#(
    parameter int CNT_W       = 11,
    parameter int TOL         = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lrck_async,
    output logic [2:0] ratio_code,
    output logic       locked,
    output logic       en_256fs,
    output logic       os_256,
    output logic       ratio_err
);
    logic             rise;
    logic             meas_valid;
    logic [CNT_W-1:0] meas_period;
    ratio_e           meas_code;
    ratio_e           ratio_q;

    mrt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .lrck_async(lrck_async), .rise(rise)
    );

    mrt_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .rise(rise),
        .meas_valid(meas_valid), .meas_period(meas_period)
    );

    mrt_ratio_classify #(.CNT_W(CNT_W), .TOL(TOL)) u_class (
        .period(meas_period), .code(meas_code)
    );

    mrt_lock_ctrl u_lock (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid),
        .meas_code(meas_code), .locked(locked), .ratio(ratio_q),
        .err(ratio_err)
    );

    mrt_en_divider u_div (
        .clk(clk), .rst_n(rst_n), .locked(locked), .ratio(ratio_q),
        .en(en_256fs)
    );

    assign ratio_code = ratio_q;
    assign os_256     = locked && (ratio_q == RAT_1024);
endmodule

// File: rtl/mrt_chk.sv
// Property checker for the ratio tracker, bound to the top module.
module mrt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] ratio_code,
    input logic       locked,
    input logic       en_256fs,
    input logic       os_256,
    input logic       ratio_err
);
    // R6
    en_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> !en_256fs);

    // R7
    en_full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && ratio_code == 3'd0) |-> en_256fs);

    // R7
    en_384_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && ratio_code == 3'd1 && en_256fs && $past(en_256fs)) |=> !en_256fs);

    // R8
    os_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        os_256 |-> (locked && ratio_code == 3'd4));

    // R4
    err_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_err |-> (!locked && ratio_code == 3'd7));

    // R5
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> $stable(ratio_code));

    // R1
    unlocked_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (ratio_code == 3'd7));
endmodule

bind mclk_ratio_tracker mrt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ratio_code(ratio_code), .locked(locked),
    .en_256fs(en_256fs), .os_256(os_256), .ratio_err(ratio_err)
);

// File: tb/sim_mclk_ratio_tracker.sv
module sim_mclk_ratio_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lrck = 1'b0;
    logic [2:0] ratio_code;
    logic       locked, en_256fs, os_256, ratio_err;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    mclk_ratio_tracker u0 (
        .clk(clk), .rst_n(rst_n), .lrck_async(lrck), .ratio_code(ratio_code),
        .locked(locked), .en_256fs(en_256fs), .os_256(os_256), .ratio_err(ratio_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        lrck  = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One frame: high half, low half, starting with a rising edge.
    task automatic one_period(input int n);
        lrck = 1'b1;
        repeat (n / 2) @(negedge clk);
        lrck = 1'b0;
        repeat (n - n / 2) @(negedge clk);
    endtask

    task automatic run_periods(input int n, input int reps);
        for (int k = 0; k < reps; k++) one_period(n);
    endtask

    task automatic expect_state(input string req, input bit lk, input int code, input bit er);
        chk(locked == lk, req, "locked", locked, lk);
        chk(ratio_code == code, req, "ratio_code", ratio_code, code);
        chk(ratio_err == er, req, "ratio_err", ratio_err, er);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs held in reset
        expect_state("R1", 1'b0, 7, 1'b0);
        chk(!en_256fs && !os_256, "R1", "en/os in reset", en_256fs, 0);
        do_reset();
        @(negedge clk);
        expect_state("R1", 1'b0, 7, 1'b0);
    endtask

    // Lock one ratio, then count enables over one frame with no edge.
    task automatic t_ratio(input int n, input int code, input int gap);
        int cnt, run0, max0;
        do_reset();
        run_periods(n, 4);
        expect_state("R3", 1'b1, code, 1'b0);
        chk(os_256 == (code == 4), "R8", "os_256", os_256, code == 4);
        cnt = 0; run0 = 0; max0 = 0;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (en_256fs) begin cnt++; run0 = 0; end
            else begin run0++; if (run0 > max0) max0 = run0; end
        end
        chk(cnt == 256, "R6", "enables per frame", cnt, 256);
        chk(max0 == gap, "R7", "longest idle run", max0, gap);
    endtask

    task automatic t_lock_timing();
        do_reset();
        run_periods(512, 2);
        // R2: one measurement only, no lock, no enables
        expect_state("R2", 1'b0, 7, 1'b0);
        chk(!en_256fs, "R6", "no enable unlocked", en_256fs, 0);
        one_period(512);
        expect_state("R2", 1'b1, 2, 1'b0);
    endtask

    task automatic t_tolerance();
        do_reset();
        one_period(510);
        one_period(514);
        one_period(512);
        // R3: 510 and 514 within window of 512
        expect_state("R3", 1'b1, 2, 1'b0);
        one_period(515);
        one_period(512);
        expect_state("R3", 1'b0, 7, 1'b1);
        one_period(509);
        one_period(512);
        expect_state("R3", 1'b0, 7, 1'b1);
    endtask

    task automatic t_unsupported();
        do_reset();
        run_periods(640, 3);
        expect_state("R4", 1'b0, 7, 1'b1);
        run_periods(512, 2);
        // R4: supported period clears error, lock not yet
        expect_state("R4", 1'b0, 7, 1'b0);
        one_period(512);
        expect_state("R4", 1'b1, 2, 1'b0);
        do_reset();
        run_periods(2560, 3);
        // R4: saturation, no wrap to 512
        expect_state("R4", 1'b0, 7, 1'b1);
    endtask

    task automatic t_change();
        do_reset();
        run_periods(512, 4);
        expect_state("R5", 1'b1, 2, 1'b0);
        run_periods(768, 2);
        // R5: class change drops lock
        expect_state("R5", 1'b0, 7, 1'b0);
        chk(!en_256fs, "R5", "enable after unlock", en_256fs, 0);
        one_period(768);
        expect_state("R5", 1'b1, 3, 1'b0);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_ratio(256, 0, 0);
        t_ratio(384, 1, 1);
        t_ratio(512, 2, 1);
        t_ratio(768, 3, 2);
        t_ratio(1024, 4, 3);
        t_lock_timing();
        t_tolerance();
        t_unsupported();
        t_change();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule